// File: doc/BRIEF.md
# Non-PCM Data Burst Detector

This block watches a stream of decoded digital-audio subframe words and decides whether that stream carries compressed, non-linear data instead of ordinary PCM audio. It has two independent routes to that decision. The first is the non-audio flag taken from the channel-status block, which is passed straight to the output. The second looks inside the samples for an in-band burst preamble: a run of silent subframes, then two fixed sync words in back-to-back subframes.

The flag route exists because some transmitters never set the non-audio flag, so the in-band route must work while the flag reads "audio". When the preamble is found, a frame-counting hold timer keeps the indication high for 4096 frames. The indication stays up across the gaps between bursts, so downstream logic can mute or reroute the stream without toggling between bursts.

The output is a level. It is the OR of the flag and the hold timer being active. The block does not decode the burst payload or the burst-info word.

Top module: `nonpcm_burst_detect`

## Requirements
- R1: After reset the hold timer is inactive, so `dataPresent` is low while `nonAudioFlag` is low.
- R2: While `nonAudioFlag` is high, `dataPresent` is high in the same cycle, with no clock edge in between.
- R3: A sync hit is declared when two subframes arrive in consecutive strobes, the first with upper 16 bits equal to 0xF872 and the second with upper 16 bits equal to 0x4E1F, and at least four zero subframes directly precede the first. `dataPresent` rises after the clock edge that accepts the second sync subframe.
- R4: If fewer than four zero subframes directly precede the 0xF872 subframe, no sync hit is declared.
- R5: No sync hit is declared if any other subframe comes between 0xF872 and 0x4E1F, or if 0x4E1F arrives without a qualified 0xF872 before it.
- R6: After a sync hit, `dataPresent` stays high until the clock edge that accepts the 4096th frame strobe counted from the hit. It is low from then on, unless the flag is high or another hit occurs.
- R7: A sync hit during an active hold reloads the timer to the full 4096 frames.
- R8: Only the upper 16 bits of `sampleWord` are examined, both for the sync values and for a subframe to count as zero. The lower bits are ignored.
- R9: The zero-run count saturates, so any run of four or more zero subframes, however long, qualifies a following sync pair.
- R10: The sync route works while `nonAudioFlag` is low. `dataPresent` equals the flag OR'd with the hold timer being active.
- R11: `sampleWord` is ignored in cycles where `subStrobe` is low. Such a cycle neither breaks a zero run nor separates the two sync subframes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleWord | input | WORD_W (24) | Decoded subframe sample, MSB-aligned |
| subStrobe | input | 1 | Marks a cycle where `sampleWord` holds a new subframe |
| frameStrobe | input | 1 | One pulse per frame; advances the hold timer |
| nonAudioFlag | input | 1 | Channel-status flag; high means non-audio data |
| dataPresent | output | 1 | High while compressed data is indicated |

## Verification
The hardest situation to reach from the ports is the exact end of the hold window. To see it, a qualified sync pair must be built, and then exactly 4095 and exactly 4096 frame strobes must follow, with no stray zero-plus-sync sequence reloading the timer. The stimulus uses directed sequences with one frame strobe per cycle to walk across that boundary, and again after a reload in the middle of a hold. It also includes near-miss preambles: three zeros only, an interruption between the sync words, and idle non-strobe cycles placed inside the pattern. A long seeded random phase then biases the words toward zero and the two sync values, so qualified pairs, partial pairs and reloads happen repeatedly. Every cycle of that phase is compared against a bench model.

// File: rtl/nonpcm_pkg.sv
package nonpcm_pkg;

  // Classification of the current subframe, produced by the datapath
  typedef struct packed {
    logic isZero;
    logic isSyncA;
    logic isSyncB;
    logic zeroRunOk;
    logic holdActive;
  } dpFlags_t;

  // Strobes issued by the control toward the datapath
  typedef struct packed {
    logic zeroInc;
    logic zeroClr;
    logic holdLoad;
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } seqState_t;

endpackage

// File: rtl/nonpcm_datapath.sv
module nonpcm_datapath
  import nonpcm_pkg::*;
#(
  parameter int          WORD_W      = 24,
  parameter int          CMP_W       = 16,
  parameter logic [15:0] SYNC_A      = 16'hF872,
  parameter logic [15:0] SYNC_B      = 16'h4E1F,
  parameter int          MIN_ZERO    = 4,
  parameter int          HOLD_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              frameStrobe,
  input  ctrlStrobes_t      strb,
  output dpFlags_t          flags
);

  localparam int ZERO_W = $clog2(MIN_ZERO + 1);
  localparam int HOLD_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [ZERO_W-1:0] ZERO_MAX = ZERO_W'(MIN_ZERO);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_FRAMES);

  logic [CMP_W-1:0]  topField;
  logic [ZERO_W-1:0] zeroRun;
  logic [HOLD_W-1:0] holdCnt;

  // Upper field only; a narrower word is used as-is
  generate
    if (WORD_W > CMP_W) begin : g_slice
      assign topField = sampleWord[WORD_W-1 -: CMP_W];
    end else begin : g_full
      assign topField = CMP_W'(sampleWord);
    end
  endgenerate

  assign flags.isZero     = (topField == '0);
  assign flags.isSyncA    = (topField == CMP_W'(SYNC_A));
  assign flags.isSyncB    = (topField == CMP_W'(SYNC_B));
  assign flags.zeroRunOk  = (zeroRun == ZERO_MAX);
  assign flags.holdActive = (holdCnt != '0);

  // Saturating zero-run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
    end else if (strb.zeroClr) begin
      zeroRun <= '0;
    end else if (strb.zeroInc && zeroRun != ZERO_MAX) begin
      zeroRun <= zeroRun + 1'b1;
    end
  end

  // Frame-based hold timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strb.holdLoad) begin
      holdCnt <= HOLD_MAX;
    end else if (frameStrobe && holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // R9
  zero_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroRun <= ZERO_MAX);

  // R7
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdLoad |=> holdCnt == HOLD_MAX);

  // R6
  hold_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !strb.holdLoad && holdCnt != '0)
      |=> holdCnt == $past(holdCnt) - HOLD_W'(1));

  // R6
  hold_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStrobe && !strb.holdLoad) |=> $stable(holdCnt));

endmodule

// File: rtl/nonpcm_control.sv
module nonpcm_control
  import nonpcm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         subStrobe,
  input  dpFlags_t     flags,
  output ctrlStrobes_t strb
);

  seqState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    if (subStrobe) begin
      if (state == ST_ARMED && flags.isSyncB) begin
        strb.holdLoad = 1'b1;
        strb.zeroClr  = 1'b1;
        nextState     = ST_IDLE;
      end else if (flags.isSyncA && flags.zeroRunOk) begin
        strb.zeroClr = 1'b1;
        nextState    = ST_ARMED;
      end else begin
        nextState = ST_IDLE;
        if (flags.isZero) strb.zeroInc = 1'b1;
        else              strb.zeroClr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R5
  load_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdLoad |-> state == ST_ARMED);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !subStrobe |=> $stable(state));

  // R4
  arm_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ARMED) |-> $past(flags.zeroRunOk && flags.isSyncA));

endmodule

// File: rtl/nonpcm_burst_detect.sv
module nonpcm_burst_detect
  import nonpcm_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int MIN_ZERO    = 4,
  parameter int HOLD_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              subStrobe,
  input  logic              frameStrobe,
  input  logic              nonAudioFlag,
  output logic              dataPresent
);

  dpFlags_t     flags;
  ctrlStrobes_t strb;

  nonpcm_datapath #(
    .WORD_W(WORD_W), .CMP_W(16), .SYNC_A(16'hF872), .SYNC_B(16'h4E1F),
    .MIN_ZERO(MIN_ZERO), .HOLD_FRAMES(HOLD_FRAMES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sampleWord(sampleWord),
    .frameStrobe(frameStrobe), .strb(strb), .flags(flags)
  );

  nonpcm_control ctl_i (
    .clk(clk), .rstN(rstN), .subStrobe(subStrobe),
    .flags(flags), .strb(strb)
  );

  assign dataPresent = nonAudioFlag | flags.holdActive;

  // R2
  flag_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    nonAudioFlag |-> dataPresent);

  // R3
  hit_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdLoad |=> dataPresent);

endmodule

// File: tb/nonpcm_burst_detect_tb_top.sv
`timescale 1ns/1ps
module nonpcm_burst_detect_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] sampleWord = '0;
  logic        subStrobe = 1'b0;
  logic        frameStrobe = 1'b0;
  logic        nonAudioFlag = 1'b0;
  logic        dataPresent;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // model state
  int  mZero = 0;
  bit  mArmed = 0;
  int  mHold = 0;

  always #4 clk = ~clk;

  nonpcm_burst_detect dut_i (
    .clk(clk), .rstN(rstN), .sampleWord(sampleWord), .subStrobe(subStrobe),
    .frameStrobe(frameStrobe), .nonAudioFlag(nonAudioFlag),
    .dataPresent(dataPresent)
  );

  function automatic bit expOut(input bit fl);
    return fl | (mHold != 0);
  endfunction

  function automatic void modelUpdate(input logic [23:0] w, input bit s, input bit f);
    bit hit = 0;
    logic [15:0] top = w[23:8];
    if (s) begin
      if (mArmed && top == 16'h4E1F) begin
        hit = 1; mArmed = 0; mZero = 0;
      end else if (top == 16'hF872 && mZero >= 4) begin
        mArmed = 1; mZero = 0;
      end else begin
        mArmed = 0;
        mZero = (top == 16'h0) ? ((mZero < 4) ? mZero + 1 : 4) : 0;
      end
    end
    if (hit) mHold = 4096;
    else if (f && mHold > 0) mHold = mHold - 1;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dataPresent=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [23:0] w, input bit s, input bit f,
                      input bit fl, input string tag);
    @(negedge clk);
    sampleWord = w; subStrobe = s; frameStrobe = f; nonAudioFlag = fl;
    #1;
    check(dataPresent, expOut(fl), tag);
    @(posedge clk);
    modelUpdate(w, s, f);
  endtask

  task automatic probe(input logic exp, input string tag);
    @(negedge clk);
    subStrobe = 0; frameStrobe = 0;
    #1;
    check(dataPresent, exp, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; subStrobe = 0; frameStrobe = 0; nonAudioFlag = 0; sampleWord = '0;
    mZero = 0; mArmed = 0; mHold = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) step({16'h0, 8'($urandom)}, 1, 0, 0, tag);
  endtask

  task automatic syncPair(input string tag);
    step(24'hF87200, 1, 0, 0, tag);
    step(24'h4E1F00, 1, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    doReset();

    // R1 reset state
    probe(1'b0, "R1");

    // R2 / R10 flag passes through combinationally
    step(24'h123456, 0, 0, 1, "R2");
    probe(1'b1, "R2");
    step(24'h0, 0, 0, 0, "R10");
    probe(1'b0, "R10");

    // R3 basic detection, R6 exact hold length
    zeros(4, "R3");
    syncPair("R3");
    probe(1'b1, "R3");
    for (int i = 0; i < 4095; i++) step(24'h0, 0, 1, 0, "R6");
    probe(1'b1, "R6");
    step(24'h0, 0, 1, 0, "R6");
    probe(1'b0, "R6");

    // R4 three zeros only
    doReset();
    step(24'h777700, 1, 0, 0, "R4");
    zeros(3, "R4");
    syncPair("R4");
    probe(1'b0, "R4");

    // R5 interruption between sync words, and lone second word
    doReset();
    zeros(5, "R5");
    step(24'hF87200, 1, 0, 0, "R5");
    step(24'h000000, 1, 0, 0, "R5");
    step(24'h4E1F00, 1, 0, 0, "R5");
    probe(1'b0, "R5");
    zeros(6, "R5");
    step(24'h4E1F00, 1, 0, 0, "R5");
    probe(1'b0, "R5");

    // R8 lower bits ignored
    doReset();
    for (int i = 0; i < 4; i++) step({16'h0, 8'hA5}, 1, 0, 0, "R8");
    step(24'hF872FF, 1, 0, 0, "R8");
    step(24'h4E1F3C, 1, 0, 0, "R8");
    probe(1'b1, "R8");

    // R9 long zero run still qualifies
    doReset();
    zeros(100, "R9");
    syncPair("R9");
    probe(1'b1, "R9");

    // R11 non-strobe cycles inside the pattern are ignored
    doReset();
    zeros(2, "R11");
    step(24'hFFFFFF, 0, 0, 0, "R11");
    zeros(2, "R11");
    step(24'hF87200, 1, 0, 0, "R11");
    step(24'h123400, 0, 0, 0, "R11");
    step(24'h4E1F00, 1, 0, 0, "R11");
    probe(1'b1, "R11");

    // R7 reload during hold
    doReset();
    zeros(4, "R7");
    syncPair("R7");
    for (int i = 0; i < 1000; i++) step(24'h0, 0, 1, 0, "R7");
    zeros(4, "R7");
    syncPair("R7");
    for (int i = 0; i < 4095; i++) step(24'h0, 0, 1, 0, "R7");
    probe(1'b1, "R7");
    step(24'h0, 0, 1, 0, "R7");
    probe(1'b0, "R7");

    // R3 / R10 seeded random phase against the model
    doReset();
    for (int i = 0; i < 20000; i++) begin
      logic [23:0] w;
      int cat = int'($urandom % 9);
      case (cat)
        0, 1, 2, 3: w = {16'h0, 8'($urandom)};
        4:          w = {16'hF872, 8'($urandom)};
        5:          w = {16'h4E1F, 8'($urandom)};
        6:          w = 24'($urandom);
        default:    w = 24'h0;
      endcase
      step(w, ($urandom % 4) != 0, ($urandom % 2) == 0,
           ($urandom % 64) == 0, "R3");
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule